// File: doc/BRIEF.md
# Asynchronous Strobe and Handshake Transfer Unit

This unit carries one parallel data word at a time from a source side to a destination side. The two sides have no shared timing agreement, so all coordination runs over three bus control lines: strobe, acknowledge and data-ready. Both sides sit in one clock domain. Fixed strobe and settle times are modelled with cycle counters whose lengths are parameters.

A two-bit mode register picks one of four protocols. Bit 0 of the mode chooses which side starts the transfer (0 = source, 1 = destination). Bit 1 chooses between a fixed-time strobe (0) and an interlocked four-phase handshake (1). In the fixed-time modes nothing feeds back, and the timing alone frames the word. In the handshake modes the sender waits for the acknowledge line or the data-ready line before it moves on.

Source logic writes a word with a one-cycle request and then watches the busy flag. Destination logic reads `dst_data` on each one-cycle valid pulse. In the destination-initiated modes, destination logic asks for a word with a one-cycle pull. The bus lines and the bus data are outputs, so the whole protocol can be observed.

Top module: `async_xfer_unit`

## Requirements
- R1: While reset is high, and on the first cycle after it, `bus_strobe`, `bus_ack`, `bus_rdy`, `src_busy` and `dst_valid` are low, `dst_data` and `bus_data` are zero, and `mode_q` reads 0.
- R2: In mode 0 (source-initiated strobe), an accepted request places the word on `bus_data` one cycle before `bus_strobe` rises. `bus_strobe` then stays high for exactly STROBE_W cycles. The destination captures the word into `dst_data` on the cycle after the strobe rises.
- R3: In mode 1 (destination-initiated strobe), the source loads a word and waits. A pull raises `bus_strobe` for exactly SETTLE_W cycles. The destination samples `bus_data` in the last strobe cycle and then drops the strobe. The source becomes idle after the strobe falls.
- R4: In mode 2 (source-initiated handshake), `bus_strobe` stays high until `bus_ack` rises, and `bus_ack` rises only while the strobe is high. The destination captures the word when it raises `bus_ack`. It drops `bus_ack` after the strobe falls, and the source becomes idle only after that.
- R5: In mode 3 (destination-initiated handshake), a pull raises `bus_strobe` as a request. A loaded source answers by raising `bus_rdy`. The destination captures the word and drops the request. The source then drops `bus_rdy`. `bus_rdy` rises only while the request is high, and the request falls only while `bus_rdy` is high.
- R6: `dst_valid` is high for exactly one clock for each completed transfer, and never for two clocks in a row.
- R7: A request made while `src_busy` is high is ignored. The word in flight is delivered unchanged, and no extra transfer takes place.
- R8: A mode write takes effect only when the unit is idle: not busy, no bus line high, and no request or pull in the same cycle. Otherwise the write is ignored. `mode_q` never changes while `src_busy` is high.
- R9: In the source-initiated modes (0 and 2), `dst_take` has no effect: no strobe and no valid pulse follow.
- R10: In the source-initiated modes, `bus_data` stays stable for as long as `bus_strobe` or `bus_ack` is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Mode write strobe |
| mode_in | input | 2 | New mode value (0..3) |
| mode_q | output | 2 | Current mode |
| src_req | input | 1 | One-cycle source write request |
| src_data | input | DW | Source word |
| src_busy | output | 1 | Source side has a transfer in progress |
| dst_take | input | 1 | One-cycle destination pull (modes 1 and 3) |
| dst_data | output | DW | Last captured word |
| dst_valid | output | 1 | One-cycle pulse per completed transfer |
| bus_data | output | DW | Word driven on the bus by the source |
| bus_strobe | output | 1 | Strobe or request line |
| bus_ack | output | 1 | Acknowledge line from the destination |
| bus_rdy | output | 1 | Data-ready line from the source |

## Verification
The properties assume that requests and pulls are single-cycle pulses and that a destination-initiated pull comes only after the source has been loaded. They also assume that mode writes fall in idle windows, although the unit itself drops writes made at other times. The stimulus meets these assumptions by loading the word before pulling and by waiting until the bus is quiet before each mode change. The busy-time request and the busy-time mode write are the only deliberate breaches, and they are covered by R7 and R8.

// File: rtl/axu_pkg.sv
package axu_pkg;

    typedef enum logic [1:0] {
        XM_SRC_STB = 2'd0,
        XM_DST_STB = 2'd1,
        XM_SRC_HS  = 2'd2,
        XM_DST_HS  = 2'd3
    } xfer_mode_e;

    typedef enum logic [2:0] {
        SS_IDLE,
        SS_SETUP,
        SS_STROBE,
        SS_ACK_LOW,
        SS_HOLD
    } src_state_e;

    typedef enum logic [1:0] {
        DS_IDLE,
        DS_STROBE,
        DS_WAIT_RDY,
        DS_RELEASE
    } dst_state_e;

    function automatic logic dst_led(xfer_mode_e m);
        return m[0];
    endfunction

    function automatic logic interlocked(xfer_mode_e m);
        return m[1];
    endfunction

endpackage

// File: rtl/axu_mode_reg.sv
module axu_mode_reg
    import axu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [1:0] wdata,
    input  logic       unit_idle,
    output xfer_mode_e mode
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= XM_SRC_STB;
        end else if (we && unit_idle) begin
            mode <= xfer_mode_e'(wdata);
        end
    end
endmodule

// File: rtl/axu_src_side.sv
module axu_src_side
    import axu_pkg::*;
#(
    parameter int DW       = 8,
    parameter int STROBE_W = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  xfer_mode_e    mode,
    input  logic          req,
    input  logic [DW-1:0] din,
    input  logic          strobe_in,
    input  logic          ack_in,
    output logic          strobe_out,
    output logic          rdy_out,
    output logic [DW-1:0] bus_data,
    output logic          busy
);
    localparam int CW = (STROBE_W > 1) ? $clog2(STROBE_W + 1) : 1;

    src_state_e    state;
    logic [CW-1:0] cnt;
    logic          stb_q;

    assign busy = (state != SS_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SS_IDLE;
            strobe_out <= 1'b0;
            rdy_out    <= 1'b0;
            bus_data   <= '0;
            cnt        <= '0;
            stb_q      <= 1'b0;
        end else begin
            stb_q <= strobe_in;
            case (state)
                SS_IDLE: begin
                    if (req) begin
                        bus_data <= din;
                        state    <= dst_led(mode) ? SS_HOLD : SS_SETUP;
                    end
                end
                SS_SETUP: begin
                    strobe_out <= 1'b1;
                    cnt        <= CW'(STROBE_W - 1);
                    state      <= SS_STROBE;
                end
                SS_STROBE: begin
                    if (interlocked(mode)) begin
                        if (ack_in) begin
                            strobe_out <= 1'b0;
                            state      <= SS_ACK_LOW;
                        end
                    end else if (cnt == '0) begin
                        strobe_out <= 1'b0;
                        state      <= SS_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                SS_ACK_LOW: begin
                    if (!ack_in) state <= SS_IDLE;
                end
                SS_HOLD: begin
                    if (interlocked(mode)) begin
                        if (!rdy_out && strobe_in) begin
                            rdy_out <= 1'b1;
                        end else if (rdy_out && !strobe_in) begin
                            rdy_out <= 1'b0;
                            state   <= SS_IDLE;
                        end
                    end else if (stb_q && !strobe_in) begin
                        state <= SS_IDLE;
                    end
                end
                default: state <= SS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/axu_dst_side.sv
module axu_dst_side
    import axu_pkg::*;
#(
    parameter int DW       = 8,
    parameter int SETTLE_W = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  xfer_mode_e    mode,
    input  logic          take,
    input  logic          strobe_in,
    input  logic          rdy_in,
    input  logic [DW-1:0] bus_data,
    output logic          strobe_out,
    output logic          ack_out,
    output logic [DW-1:0] dout,
    output logic          valid,
    output logic          idle
);
    localparam int CW = (SETTLE_W > 1) ? $clog2(SETTLE_W + 1) : 1;

    dst_state_e    state;
    logic [CW-1:0] cnt;
    logic          stb_q;

    assign idle = (state == DS_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= DS_IDLE;
            strobe_out <= 1'b0;
            ack_out    <= 1'b0;
            dout       <= '0;
            valid      <= 1'b0;
            cnt        <= '0;
            stb_q      <= 1'b0;
        end else begin
            stb_q <= strobe_in;
            valid <= 1'b0;
            case (state)
                DS_IDLE: begin
                    case (mode)
                        XM_SRC_STB: begin
                            if (strobe_in && !stb_q) begin
                                dout  <= bus_data;
                                valid <= 1'b1;
                            end
                        end
                        XM_SRC_HS: begin
                            if (strobe_in && !ack_out) begin
                                dout    <= bus_data;
                                valid   <= 1'b1;
                                ack_out <= 1'b1;
                                state   <= DS_RELEASE;
                            end
                        end
                        XM_DST_STB: begin
                            if (take) begin
                                strobe_out <= 1'b1;
                                cnt        <= CW'(SETTLE_W - 1);
                                state      <= DS_STROBE;
                            end
                        end
                        default: begin
                            if (take) begin
                                strobe_out <= 1'b1;
                                state      <= DS_WAIT_RDY;
                            end
                        end
                    endcase
                end
                DS_STROBE: begin
                    if (cnt == '0) begin
                        dout       <= bus_data;
                        valid      <= 1'b1;
                        strobe_out <= 1'b0;
                        state      <= DS_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                DS_WAIT_RDY: begin
                    if (rdy_in) begin
                        dout       <= bus_data;
                        valid      <= 1'b1;
                        strobe_out <= 1'b0;
                        state      <= DS_RELEASE;
                    end
                end
                DS_RELEASE: begin
                    if (mode == XM_SRC_HS) begin
                        if (!strobe_in) begin
                            ack_out <= 1'b0;
                            state   <= DS_IDLE;
                        end
                    end else if (!rdy_in) begin
                        state <= DS_IDLE;
                    end
                end
                default: state <= DS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/async_xfer_unit.sv
module async_xfer_unit
    import axu_pkg::*;
#(
    parameter int DW       = 8,
    parameter int STROBE_W = 3,
    parameter int SETTLE_W = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_we,
    input  logic [1:0]    mode_in,
    output logic [1:0]    mode_q,
    input  logic          src_req,
    input  logic [DW-1:0] src_data,
    output logic          src_busy,
    input  logic          dst_take,
    output logic [DW-1:0] dst_data,
    output logic          dst_valid,
    output logic [DW-1:0] bus_data,
    output logic          bus_strobe,
    output logic          bus_ack,
    output logic          bus_rdy
);
    xfer_mode_e mode;
    logic       src_stb;
    logic       dst_stb;
    logic       dst_idle;
    logic       unit_idle;

    assign mode_q     = mode;
    assign bus_strobe = dst_led(mode) ? dst_stb : src_stb;
    assign unit_idle  = !src_busy && dst_idle && !bus_strobe && !bus_ack
                        && !bus_rdy && !src_req && !dst_take;

    axu_mode_reg mode_i (
        .clk       (clk),
        .rst       (rst),
        .we        (mode_we),
        .wdata     (mode_in),
        .unit_idle (unit_idle),
        .mode      (mode)
    );

    axu_src_side #(.DW(DW), .STROBE_W(STROBE_W)) src_i (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .req        (src_req),
        .din        (src_data),
        .strobe_in  (bus_strobe),
        .ack_in     (bus_ack),
        .strobe_out (src_stb),
        .rdy_out    (bus_rdy),
        .bus_data   (bus_data),
        .busy       (src_busy)
    );

    axu_dst_side #(.DW(DW), .SETTLE_W(SETTLE_W)) dst_i (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .take       (dst_take),
        .strobe_in  (bus_strobe),
        .rdy_in     (bus_rdy),
        .bus_data   (bus_data),
        .strobe_out (dst_stb),
        .ack_out    (bus_ack),
        .dout       (dst_data),
        .valid      (dst_valid),
        .idle       (dst_idle)
    );
endmodule

// File: rtl/axu_checker.sv
module axu_checker #(
    parameter int DW       = 8,
    parameter int STROBE_W = 3,
    parameter int SETTLE_W = 2
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    mode_q,
    input logic          src_busy,
    input logic [DW-1:0] bus_data,
    input logic          bus_strobe,
    input logic          bus_ack,
    input logic          bus_rdy,
    input logic          dst_valid
);
    logic [15:0] run_len;
    logic        held;

    assign held = bus_strobe || bus_ack;

    always_ff @(posedge clk) begin
        if (rst) run_len <= '0;
        else     run_len <= bus_strobe ? run_len + 16'd1 : 16'd0;
    end

    a_r2_strobe_width: assert property (@(posedge clk) disable iff (rst)
        ($fell(bus_strobe) && mode_q == 2'd0) |-> (run_len == 16'(STROBE_W)));

    a_r2_data_before_strobe: assert property (@(posedge clk) disable iff (rst)
        ($rose(bus_strobe) && mode_q == 2'd0) |-> $stable(bus_data));

    a_r3_settle_width: assert property (@(posedge clk) disable iff (rst)
        ($fell(bus_strobe) && mode_q == 2'd1) |-> (run_len == 16'(SETTLE_W)));

    a_r4_ack_within_strobe: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 2'd2 && $rose(bus_ack)) |-> bus_strobe);

    a_r4_strobe_until_ack: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 2'd2 && $fell(bus_strobe)) |-> bus_ack);

    a_r5_rdy_within_req: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 2'd3 && $rose(bus_rdy)) |-> bus_strobe);

    a_r5_req_until_rdy: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 2'd3 && $fell(bus_strobe)) |-> bus_rdy);

    a_r6_valid_single: assert property (@(posedge clk) disable iff (rst)
        dst_valid |=> !dst_valid);

    a_r8_mode_frozen: assert property (@(posedge clk) disable iff (rst)
        src_busy |=> $stable(mode_q));

    a_r10_data_held: assert property (@(posedge clk) disable iff (rst)
        (!mode_q[0] && held && $past(held)) |-> $stable(bus_data));
endmodule

bind async_xfer_unit axu_checker #(
    .DW(DW), .STROBE_W(STROBE_W), .SETTLE_W(SETTLE_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .mode_q     (mode_q),
    .src_busy   (src_busy),
    .bus_data   (bus_data),
    .bus_strobe (bus_strobe),
    .bus_ack    (bus_ack),
    .bus_rdy    (bus_rdy),
    .dst_valid  (dst_valid)
);

// File: tb/async_xfer_unit_tb_top.sv
`timescale 1ns/100ps
module async_xfer_unit_tb_top;
    localparam int DW       = 8;
    localparam int STROBE_W = 3;
    localparam int SETTLE_W = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mode_we = 1'b0;
    logic [1:0]    mode_in = '0;
    logic [1:0]    mode_q;
    logic          src_req = 1'b0;
    logic [DW-1:0] src_data = '0;
    logic          src_busy;
    logic          dst_take = 1'b0;
    logic [DW-1:0] dst_data;
    logic          dst_valid;
    logic [DW-1:0] bus_data;
    logic          bus_strobe, bus_ack, bus_rdy;

    always #2.5 clk = ~clk;

    async_xfer_unit #(.DW(DW), .STROBE_W(STROBE_W), .SETTLE_W(SETTLE_W)) dut_i (
        .clk(clk), .rst(rst), .mode_we(mode_we), .mode_in(mode_in), .mode_q(mode_q),
        .src_req(src_req), .src_data(src_data), .src_busy(src_busy),
        .dst_take(dst_take), .dst_data(dst_data), .dst_valid(dst_valid),
        .bus_data(bus_data), .bus_strobe(bus_strobe), .bus_ack(bus_ack), .bus_rdy(bus_rdy)
    );

    int total = 0;
    int bad   = 0;
    int vcount = 0;
    int double_valid = 0;
    int run = 0;
    int last_run = 0;
    int strobe_seen = 0;
    int ack_seen = 0;
    int rdy_seen = 0;
    logic [DW-1:0] last_data = '0;
    logic prev_valid = 1'b0;
    bit done = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (dst_valid) begin
                vcount++;
                last_data = dst_data;
                if (prev_valid) double_valid++;
            end
            prev_valid = dst_valid;
            if (bus_strobe) begin
                run++;
                strobe_seen = 1;
            end else if (run > 0) begin
                last_run = run;
                run = 0;
            end
            if (bus_ack) ack_seen = 1;
            if (bus_rdy) rdy_seen = 1;
        end
    end

    function automatic int exp_width(logic [1:0] m);
        return m[0] ? SETTLE_W : STROBE_W;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_quiet();
        for (int i = 0; i < 100; i++) begin
            tick();
            if (!src_busy && !bus_strobe && !bus_ack && !bus_rdy && run == 0) break;
        end
        tick();
    endtask

    task automatic set_mode(logic [1:0] m);
        @(negedge clk);
        mode_we = 1'b1;
        mode_in = m;
        @(negedge clk);
        mode_we = 1'b0;
        #1;
        chk(mode_q == m, "R8 idle mode write", mode_q, m);
    endtask

    task automatic do_xfer(logic [1:0] m, logic [DW-1:0] d);
        int start_v;
        start_v  = vcount;
        ack_seen = 0;
        rdy_seen = 0;
        @(negedge clk);
        src_req  = 1'b1;
        src_data = d;
        @(negedge clk);
        src_req  = 1'b0;
        if (m[0]) begin
            dst_take = 1'b1;
            @(negedge clk);
            dst_take = 1'b0;
        end
        for (int i = 0; i < 100; i++) begin
            if (vcount > start_v) break;
            tick();
        end
        wait_quiet();
        chk(vcount == start_v + 1, "R6 one valid per transfer", vcount - start_v, 1);
        case (m)
            2'd0: chk(last_data == d, "R2 captured word", last_data, d);
            2'd1: chk(last_data == d, "R3 captured word", last_data, d);
            2'd2: chk(last_data == d, "R4 captured word", last_data, d);
            default: chk(last_data == d, "R5 captured word", last_data, d);
        endcase
        if (!m[1]) begin
            if (m[0]) chk(last_run == exp_width(m), "R3 strobe width", last_run, exp_width(m));
            else      chk(last_run == exp_width(m), "R2 strobe width", last_run, exp_width(m));
        end else if (m == 2'd2) begin
            chk(ack_seen == 1, "R4 acknowledge seen", ack_seen, 1);
        end else begin
            chk(rdy_seen == 1, "R5 data-ready seen", rdy_seen, 1);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            chk(double_valid == 0, "R6 valid never two cycles", double_valid, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        #1;
        chk(!bus_strobe && !bus_ack && !bus_rdy && !src_busy && !dst_valid,
            "R1 lines low in reset", {bus_strobe, bus_ack, bus_rdy, src_busy, dst_valid}, 0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(mode_q == 2'd0, "R1 mode after reset", mode_q, 0);
        chk(dst_data == '0 && bus_data == '0, "R1 data zero", dst_data, 0);
        chk(!src_busy && !dst_valid, "R1 idle after reset", src_busy, 0);

        // R2 directed source strobe
        do_xfer(2'd0, 8'hA5);
        do_xfer(2'd0, 8'h00);

        // R7 request while busy is dropped
        begin
            int sv;
            sv = vcount;
            @(negedge clk);
            src_req = 1'b1; src_data = 8'h3C;
            @(negedge clk);
            src_data = 8'hC3;
            @(negedge clk);
            src_req = 1'b0;
            wait_quiet();
            wait_quiet();
            chk(vcount == sv + 1, "R7 single transfer", vcount - sv, 1);
            chk(last_data == 8'h3C, "R7 first word kept", last_data, 8'h3C);
        end

        // R8 mode write while busy is ignored
        @(negedge clk);
        src_req = 1'b1; src_data = 8'h11;
        @(negedge clk);
        src_req = 1'b0;
        mode_we = 1'b1; mode_in = 2'd3;
        @(negedge clk);
        mode_we = 1'b0;
        wait_quiet();
        chk(mode_q == 2'd0, "R8 busy mode write ignored", mode_q, 0);

        // R9 pull ignored in source modes
        for (int k = 0; k < 2; k++) begin
            int sv;
            set_mode(k == 0 ? 2'd0 : 2'd2);
            sv = vcount;
            strobe_seen = 0;
            @(negedge clk);
            dst_take = 1'b1;
            @(negedge clk);
            dst_take = 1'b0;
            repeat (10) tick();
            chk(strobe_seen == 0, "R9 no strobe from pull", strobe_seen, 0);
            chk(vcount == sv, "R9 no valid from pull", vcount - sv, 0);
        end

        // R4, R3, R5 directed
        do_xfer(2'd2, 8'h5A);
        set_mode(2'd1);
        do_xfer(2'd1, 8'hFF);
        set_mode(2'd3);
        do_xfer(2'd3, 8'h81);

        // random mix, R10 checked by its property throughout
        for (int n = 0; n < 40; n++) begin
            logic [1:0]    m;
            logic [DW-1:0] d;
            m = 2'($urandom % 4);
            d = DW'($urandom);
            set_mode(m);
            do_xfer(m, d);
        end

        finish_run();
    end
endmodule